// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the target side of a slow serial debug link. An external host drives a debug clock, a data-in line and a debug request line. The block samples all three with the system clock and finds the debug clock's edges. It takes 8-bit commands and 24-bit write data from the host. It turns them into single-cycle read and write strobes on a plain register bus toward the core. It returns read data to the host on its serial output.

The host and the port stay in step through a handshake. Every time the port is ready for the next thing from the host, it pulls the normally-high serial output low for a fixed short pulse. This happens on debug entry, after a read command (data loaded), after a write command (ready for data) and after write data (stored).

Debug mode itself is owned by the core. It is reported to the port as a flag input. While that flag is low, the shared clock and data-in pins are turned into outputs that carry two core status bits, and serial input is ignored. Raising the debug request while already in debug mode restarts the port's command sequence. This recovers a host that has lost bit alignment.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset with the debug-mode flag low, the serial output is high, the status pins are enabled as outputs, and no register strobe is issued.
- R2: The status output enable is high exactly when the debug-mode flag is low, and the status outputs then equal the core status value. In debug mode the enable is low.
- R3: A rising debug-mode flag produces one acknowledge: the serial output is low for exactly 4 system clock cycles. This includes a flag that is already high when reset is released.
- R4: A command is 8 bits, sampled on falling edges of the debug clock, most significant bit first. Bit 7 set means read and bit 7 clear means write. Bit 6 has no effect. Bits 5:0 give the register address.
- R5: After a write command the port acknowledges. It then samples 24 data bits on falling edges, MSB first, and issues one write strobe with that address and data. A second acknowledge follows.
- R6: After a read command the port issues one read strobe and acknowledges. It then presents the 24 read bits, MSB first, each one changing on a rising debug clock edge.
- R7: While the debug-mode flag is low, activity on the debug clock and data-in pins causes no register strobe and no low level on the serial output.
- R8: In debug mode, a rising debug request, even in the middle of a command, produces an acknowledge. Debug clock edges are ignored while the request stays high. After it is released, the port expects a fresh command.
- R9: The serial output is high whenever no acknowledge and no read data transfer is in progress. This includes the time after the last read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req_i | input | 1 | Debug request from the host, asynchronous |
| ser_clk_i | input | 1 | Debug serial clock from the host, asynchronous |
| ser_din_i | input | 1 | Serial command and write data from the host |
| ser_dout_o | output | 1 | Serial read data and acknowledge pulses, idles high |
| stat_o | output | 2 | Core status value driven on the shared pins |
| stat_oe_o | output | 1 | Output enable for the shared status pins |
| core_dbg_mode_i | input | 1 | Debug-mode flag from the core |
| core_status_i | input | 2 | Core status value |
| reg_addr_o | output | 6 | Register bus address |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 24 | Register bus write data |
| reg_rdata_i | input | 24 | Register bus read data, valid in the strobe cycle |

## Verification
The hardest case to reach is a debug request that arrives in the middle of a command, with partial bits already in the shift register. The port must then drop those bits and still decode the next full command correctly. The bench gets there by shifting three bits of a command, raising the request, and checking the acknowledge. It toggles the debug clock while the request is held, releases the request, and then completes a write and read-back to a fresh address. The main sweep writes and reads back all 64 addresses, with bit 6 of the command set on alternating ones.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int CMD_BITS  = 8;
  localparam int DATA_BITS = 24;
  localparam int ADDR_BITS = 6;
  localparam int STAT_BITS = 2;
  localparam int ACK_CYCLES = 4;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_HOLD,
    ST_CMD,
    ST_LOAD,
    ST_RDATA,
    ST_WDATA,
    ST_STORE
  } port_state_e;
endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dbgp_ack.sv
module dbgp_ack #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start_i)            cnt_d = CW'(CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R3
  ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
  import dbgp_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 24,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              req_i,
  input  logic              ack_busy_i,
  output logic              ack_start_o,
  output logic              tx_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int RD_BIT = CMD_W - 1;

  port_state_e       state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              tx_q, tx_d;
  logic              mode_q, sclk_q, req_q;
  logic              mode_rise, sclk_rise, sclk_fall, req_rise;
  logic [DATA_W-1:0] sh_in;
  logic              edge_ok;

  assign mode_rise = mode_i & ~mode_q;
  assign sclk_rise = sclk_i & ~sclk_q;
  assign sclk_fall = ~sclk_i & sclk_q;
  assign req_rise  = req_i & ~req_q;
  assign sh_in     = {sh_q[DATA_W-2:0], din_i};
  assign edge_ok   = ~ack_busy_i;

  always_comb begin
    state_d     = state_q;
    sh_d        = sh_q;
    cnt_d       = cnt_q;
    addr_d      = addr_q;
    tx_d        = tx_q;
    ack_start_o = 1'b0;
    if (!mode_i) begin
      state_d = ST_OFF;
      tx_d    = 1'b1;
    end else if (mode_rise) begin
      state_d     = ST_HOLD;
      ack_start_o = 1'b1;
      tx_d        = 1'b1;
    end else if (req_rise && state_q != ST_OFF && state_q != ST_HOLD) begin
      state_d     = ST_HOLD;
      ack_start_o = 1'b1;
      tx_d        = 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_OFF;
        ST_HOLD: begin
          if (edge_ok && !req_i) begin
            state_d = ST_CMD;
            cnt_d   = '0;
          end
        end
        ST_CMD: begin
          if (edge_ok && sclk_fall) begin
            sh_d  = sh_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CMD_W - 1)) begin
              addr_d = sh_in[ADDR_W-1:0];
              cnt_d  = '0;
              if (sh_in[RD_BIT]) begin
                state_d = ST_LOAD;
              end else begin
                state_d     = ST_WDATA;
                ack_start_o = 1'b1;
              end
            end
          end
        end
        ST_LOAD: begin
          sh_d        = reg_rdata_i;
          ack_start_o = 1'b1;
          cnt_d       = '0;
          tx_d        = 1'b1;
          state_d     = ST_RDATA;
        end
        ST_RDATA: begin
          if (edge_ok && sclk_rise) begin
            tx_d = sh_q[DATA_W-1];
            sh_d = {sh_q[DATA_W-2:0], 1'b0};
          end else if (edge_ok && sclk_fall) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_d   = '0;
              tx_d    = 1'b1;
              state_d = ST_CMD;
            end
          end
        end
        ST_WDATA: begin
          if (edge_ok && sclk_fall) begin
            sh_d  = sh_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_d   = '0;
              state_d = ST_STORE;
            end
          end
        end
        ST_STORE: begin
          ack_start_o = 1'b1;
          cnt_d       = '0;
          state_d     = ST_CMD;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      sh_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      tx_q    <= 1'b1;
      mode_q  <= 1'b0;
      sclk_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      tx_q    <= tx_d;
      mode_q  <= mode_i;
      sclk_q  <= sclk_i;
      req_q   <= req_i;
    end
  end

  assign tx_o        = tx_q;
  assign reg_addr_o  = addr_q;
  assign reg_rd_o    = (state_q == ST_LOAD);
  assign reg_wr_o    = (state_q == ST_STORE);
  assign reg_wdata_o = sh_q;

  // R5
  wr_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> mode_i);
  // R5
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> ack_busy_i);
  // R6
  rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> ack_busy_i);
  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> (!reg_wr_o && !reg_rd_o));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dbgp_pkg::*;
#(
  parameter int CMD_W   = CMD_BITS,
  parameter int DATA_W  = DATA_BITS,
  parameter int ADDR_W  = ADDR_BITS,
  parameter int STAT_W  = STAT_BITS,
  parameter int ACK_CYC = ACK_CYCLES,
  parameter int SYNC_N  = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_req_i,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              stat_oe_o,
  input  logic              core_dbg_mode_i,
  input  logic [STAT_W-1:0] core_status_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic       rst_meta_q, rst_int_n;
  logic [2:0] pins_sync;
  logic       ack_start, ack_busy, tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  dbgp_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({dbg_req_i, ser_clk_i, ser_din_i}),
    .sync_o  (pins_sync)
  );

  dbgp_ack #(.CYC(ACK_CYC)) u_ack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (ack_start),
    .busy_o  (ack_busy)
  );

  dbgp_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode_i      (core_dbg_mode_i),
    .sclk_i      (pins_sync[1]),
    .din_i       (pins_sync[0]),
    .req_i       (pins_sync[2]),
    .ack_busy_i  (ack_busy),
    .ack_start_o (ack_start),
    .tx_o        (tx_bit),
    .reg_addr_o  (reg_addr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i)
  );

  assign ser_dout_o = ack_busy ? 1'b0 : tx_bit;
  assign stat_oe_o  = ~core_dbg_mode_i;
  assign stat_o     = core_status_i;

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!core_dbg_mode_i && !ack_busy) |-> ser_dout_o);
endmodule

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, sclk, din, mode;
  logic [1:0]  cst;
  logic        dout, stat_oe, rd, wr;
  logic [1:0]  stat;
  logic [5:0]  addr;
  logic [23:0] wdata;
  logic [23:0] mem [64];
  int          checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  bit          low_seen;

  always #10 clk = ~clk;

  dbg_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_req_i(req), .ser_clk_i(sclk),
    .ser_din_i(din), .ser_dout_o(dout), .stat_o(stat), .stat_oe_o(stat_oe),
    .core_dbg_mode_i(mode), .core_status_i(cst), .reg_addr_o(addr),
    .reg_rd_o(rd), .reg_wr_o(wr), .reg_wdata_o(wdata), .reg_rdata_i(mem[addr])
  );

  always @(posedge clk) begin
    if (wr) begin mem[addr] <= wdata; wr_cnt <= wr_cnt + 1; end
    if (rd) rd_cnt <= rd_cnt + 1;
  end
  always @(negedge clk) if (dout === 1'b0) low_seen = 1'b1;

  function automatic logic [23:0] pat(input int a);
    return 24'((a * 32'h2F1B3 + 32'h5A3C1) ^ (a << 17));
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_ack(input string rq);
    int t = 0;
    int n = 0;
    while (dout === 1'b1 && t < 60) begin tick(1); t++; end
    while (dout === 1'b0 && n < 20) begin tick(1); n++; end
    chk(n == 4, rq, n, 4);
  endtask

  task automatic send_bits(input logic [23:0] v, input int nb, input bit last_ack, input string rq);
    for (int i = nb - 1; i >= 0; i--) begin
      din = v[i]; sclk = 1'b1; tick(8);
      sclk = 1'b0;
      if (i != 0 || !last_ack) tick(8);
    end
    if (last_ack) wait_ack(rq);
  endtask

  task automatic recv_bits(output logic [23:0] v);
    for (int i = 23; i >= 0; i--) begin
      sclk = 1'b1; tick(8);
      v[i] = dout;
      sclk = 1'b0; tick(8);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input bit b6, input logic [23:0] v);
    int w0 = wr_cnt;
    send_bits({16'h0, 1'b0, b6, a}, 8, 1'b1, "R5 cmd ack");
    send_bits(v, 24, 1'b1, "R5 data ack");
    chk(wr_cnt == w0 + 1, "R5 one strobe", wr_cnt - w0, 1);
    chk(mem[a] == v, "R5 stored R4 addr", int'(mem[a]), int'(v));
  endtask

  task automatic do_read(input logic [5:0] a, input bit b6, input logic [23:0] exp);
    logic [23:0] got;
    int r0 = rd_cnt;
    send_bits({16'h0, 1'b1, b6, a}, 8, 1'b1, "R6 read ack");
    chk(rd_cnt == r0 + 1, "R6 one strobe", rd_cnt - r0, 1);
    recv_bits(got);
    chk(got == exp, "R6 read data R4", int'(got), int'(exp));
    tick(4);
    chk(dout === 1'b1, "R9 idle after read", int'(dout), 1);
  endtask

  task automatic enter_dbg();
    req = 1'b1; tick(6);
    mode = 1'b1;
    wait_ack("R3 entry ack");
    req = 1'b0; tick(10);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; sclk = 1'b0; din = 1'b0; mode = 1'b0; cst = 2'b00;
    tick(5);
    rst_n = 1'b1; tick(10);
    // R1 reset state
    chk(dout === 1'b1, "R1 dout", int'(dout), 1);
    chk(stat_oe === 1'b1, "R1 stat_oe", int'(stat_oe), 1);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes", wr_cnt + rd_cnt, 0);

    // R2 status pins sweep
    for (int s = 0; s < 4; s++) begin
      cst = 2'(s); tick(1);
      chk(stat === 2'(s) && stat_oe === 1'b1, "R2 status out", int'({stat_oe, stat}), 4 + s);
    end

    // R3 entry with flag high at reset release
    rst_n = 1'b0; mode = 1'b1; tick(3);
    rst_n = 1'b1;
    wait_ack("R3 ack at reset release");
    tick(10);
    chk(stat_oe === 1'b0, "R2 oe off in debug", int'(stat_oe), 0);

    // R7 input ignored outside debug mode
    mode = 1'b0; tick(10);
    low_seen = 1'b0;
    send_bits(24'hFFFFFF, 8, 1'b0, "R7");
    send_bits(24'hA5A5A5, 24, 1'b0, "R7");
    send_bits(24'h0000C1, 8, 1'b0, "R7");
    tick(20);
    chk(wr_cnt == 0 && rd_cnt == 0, "R7 no strobes", wr_cnt + rd_cnt, 0);
    chk(!low_seen, "R7 dout stayed high", int'(low_seen), 0);

    // R3/R4/R5/R6 full address sweep
    enter_dbg();
    for (int a = 0; a < 64; a++) do_write(6'(a), a[0], pat(a));
    for (int a = 0; a < 64; a++) do_read(6'(a), ~a[0], pat(a));

    // R8 resync in the middle of a command
    send_bits(24'h5, 3, 1'b0, "R8");
    req = 1'b1;
    wait_ack("R8 resync ack");
    send_bits(24'hFF, 8, 1'b0, "R8 held");
    tick(10);
    chk(rd_cnt == 64 && wr_cnt == 64, "R8 no strobe while held", rd_cnt + wr_cnt, 128);
    req = 1'b0; tick(10);
    do_write(6'd37, 1'b0, 24'h13579B);
    do_read(6'd37, 1'b1, 24'h13579B);
    do_read(6'd0, 1'b0, pat(0));

    finish_run();
  end
endmodule